// File: doc/BRIEF.md
# Single-Wire Bus Master

This block is the master for a single-wire, open-drain serial bus. It builds every bus waveform out of a 1 MHz time base. That base comes from the system clock, divided by a value that software sets. Software drives the block through a small byte-wide register file.

A write to the command register with the reset bit set starts a bus reset. The reset pulls the line low, releases it, and checks whether any device on the bus answers with a presence pulse. Once a reset has completed, a write to the data register sends one byte as eight time slots, least significant bit first:

- A one bit is sent with a short low pulse. The same slot also serves as a read slot, because the line is sampled partway through the slot.
- A zero bit holds the line low for most of the slot.

The sampled values are gathered into a receive byte. Software can also pull the line low directly through a guarded override. The override acts only while its enable bit in the control register is set.

The line is modelled as a pull-down enable, `line_pd_o`. The bus level comes back in on `line_i`.

Top module: `owm_master`

Register map, as seen through `wr_addr_i` and `rd_addr_i`:

| Addr | Name | Write | Read |
|------|------|-------|------|
| 0 | command | bit0 starts a reset; bit2 is the force request | last accepted byte |
| 1 | control | bit2 is the force enable | stored byte |
| 2 | divisor | clocks per base tick | stored value |
| 3 | data | starts a byte transfer | receive byte |
| 4 | status | none | bit0 busy, bit1 presence, bit2 no presence, bit3 reset done |

## Requirements
- R1: The base tick fires once every D system clocks, where D is the divisor register at address 2. A divisor of 0 acts as 1. Every slot duration below is counted in base ticks.
- R2: A command write (address 0) with bit0 set, made while idle, starts a reset. The reset drives the line low for RST_LOW ticks and keeps the block busy for RST_LOW+RST_WAIT+RST_TAIL ticks in total.
- R3: The reset samples the line RST_LOW+RST_WAIT ticks after it starts. A low line sets status bit1 (presence). A high line sets status bit2 (no presence). Both bits clear when a reset starts, and they are never set together.
- R4: A data write (address 3) is ignored until a reset has completed. Status bit3 reports that a reset has completed.
- R5: Once a reset has completed, a data write made while idle sends the byte as 8 slots, least significant bit first, each SLOT_TICKS long. A one bit drives the line low for W1_LOW ticks and a zero bit for W0_LOW ticks.
- R6: Each data slot samples the line RD_SMP ticks after the slot starts. The sample shifts into the receive byte from the top, so bit 0 of the byte was sent first. Reading address 3 returns the receive byte.
- R7: Status bit0 (busy) is set from the clock edge that accepts a command until the last slot ends. Command and data writes made while busy are ignored.
- R8: While control bit2 (force enable) is set, command bit2 pulls the line low. While the enable is clear, command bit2 has no effect on the line.
- R9: After reset the line is released, status is 0, the receive byte is 0, and the divisor holds DIV_INIT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data for `rd_addr_i` (combinational) |
| line_i | input | 1 | Sensed bus level |
| line_pd_o | output | 1 | Pull-down enable for the open-drain bus line |

## Verification
The bench builds the block with shortened timing parameters:

| Parameter | Value |
|-----------|-------|
| RST_LOW | 12 |
| RST_WAIT | 4 |
| RST_TAIL | 6 |
| W1_LOW | 2 |
| W0_LOW | 8 |
| SLOT_TICKS | 10 |
| RD_SMP | 4 |
| DIV_INIT | 5 |

With these values a full reset plus several byte transfers fit in a few thousand clocks. The ordering W1_LOW < RD_SMP < W0_LOW is kept, so a one slot reads back the device and a zero slot reads back the master's own pull.

The divisor is set to 3, 1 and 0 during the run. Every divider phase relative to a command start is therefore reached, and so is the case where the divisor is treated as 1.

// File: rtl/owm_pkg.sv
package owm_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_RST  = 2'd1,
    SLOT_BIT  = 2'd2
  } slot_kind_e;

  localparam logic [2:0] ADDR_CMD  = 3'd0;
  localparam logic [2:0] ADDR_CTRL = 3'd1;
  localparam logic [2:0] ADDR_DIV  = 3'd2;
  localparam logic [2:0] ADDR_DATA = 3'd3;
  localparam logic [2:0] ADDR_STAT = 3'd4;

  localparam int CMD_RST_BIT   = 0;
  localparam int CMD_FORCE_BIT = 2;
  localparam int CTRL_FEN_BIT  = 2;
endpackage

// File: rtl/owm_tick_gen.sv
module owm_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim    = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tick_o = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R1: with a divisor above one, ticks never come back to back
  p_tick_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i > 1) |=> (!tick_o || div_i != $past(div_i)));
endmodule

// File: rtl/owm_slot_engine.sv
module owm_slot_engine
  import owm_pkg::*;
#(
  parameter int RST_LOW    = 480,
  parameter int RST_WAIT   = 70,
  parameter int RST_TAIL   = 410,
  parameter int W1_LOW     = 6,
  parameter int W0_LOW     = 60,
  parameter int SLOT_TICKS = 70,
  parameter int RD_SMP     = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_rst_i,
  input  logic       start_byte_i,
  input  logic [7:0] tx_i,
  input  logic       line_i,
  output logic       busy_o,
  output logic       pd_o,
  output logic [7:0] rx_o,
  output logic       presence_o,
  output logic       nopres_o,
  output logic       rst_done_o
);
  localparam int RST_TOTAL = RST_LOW + RST_WAIT + RST_TAIL;
  localparam int TW        = $clog2(RST_TOTAL + 1);

  localparam logic [TW-1:0] C_RST_LOW = TW'(RST_LOW);
  localparam logic [TW-1:0] C_RST_SMP = TW'(RST_LOW + RST_WAIT);
  localparam logic [TW-1:0] C_RST_TOT = TW'(RST_TOTAL);
  localparam logic [TW-1:0] C_W1_LOW  = TW'(W1_LOW);
  localparam logic [TW-1:0] C_W0_LOW  = TW'(W0_LOW);
  localparam logic [TW-1:0] C_SLOT    = TW'(SLOT_TICKS);
  localparam logic [TW-1:0] C_RD_SMP  = TW'(RD_SMP);

  slot_kind_e    kind_q;
  logic [TW-1:0] tcnt_q;
  logic [TW-1:0] tnext;
  logic [TW-1:0] cur_low;
  logic [TW-1:0] cur_smp;
  logic [TW-1:0] cur_tot;
  logic [2:0]    bit_q;
  logic [7:0]    tx_q;
  logic [7:0]    rx_q;
  logic          pres_q;
  logic          nopres_q;
  logic          done_q;
  logic          is_rst;

  assign is_rst  = (kind_q == SLOT_RST);
  assign cur_low = is_rst ? C_RST_LOW : (tx_q[0] ? C_W1_LOW : C_W0_LOW);
  assign cur_smp = is_rst ? C_RST_SMP : C_RD_SMP;
  assign cur_tot = is_rst ? C_RST_TOT : C_SLOT;
  assign tnext   = tcnt_q + 1'b1;

  assign busy_o     = (kind_q != SLOT_IDLE);
  assign pd_o       = busy_o && (tcnt_q < cur_low);
  assign rx_o       = rx_q;
  assign presence_o = pres_q;
  assign nopres_o   = nopres_q;
  assign rst_done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q   <= SLOT_IDLE;
      tcnt_q   <= '0;
      bit_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      pres_q   <= 1'b0;
      nopres_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (start_rst_i) begin
      kind_q   <= SLOT_RST;
      tcnt_q   <= '0;
      pres_q   <= 1'b0;
      nopres_q <= 1'b0;
    end else if (start_byte_i) begin
      kind_q <= SLOT_BIT;
      tcnt_q <= '0;
      bit_q  <= '0;
      tx_q   <= tx_i;
    end else if (busy_o && tick_i) begin
      tcnt_q <= tnext;
      if (tnext == cur_smp) begin
        if (is_rst) begin
          pres_q   <= !line_i;
          nopres_q <= line_i;
        end else begin
          rx_q <= {line_i, rx_q[7:1]};
        end
      end
      if (tnext == cur_tot) begin
        tcnt_q <= '0;
        if (is_rst) begin
          kind_q <= SLOT_IDLE;
          done_q <= 1'b1;
        end else if (bit_q == 3'd7) begin
          kind_q <= SLOT_IDLE;
        end else begin
          bit_q <= bit_q + 1'b1;
          tx_q  <= {1'b0, tx_q[7:1]};
        end
      end
    end
  end

  // R3: the two presence outcomes exclude each other
  p_pres_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pres_q && nopres_q));

  // R3: starting a reset clears the previous outcome
  p_pres_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_rst_i |=> (!presence_o && !nopres_o));

  // R7: a start is only accepted while idle
  p_start_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_rst_i || start_byte_i) |-> !busy_o);

  // R5: the busy flag drops right after the eighth slot ends
  p_byte_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_q == SLOT_BIT && tick_i && tnext == cur_tot && bit_q == 3'd7
     && !start_rst_i && !start_byte_i) |=> !busy_o);
endmodule

// File: rtl/owm_master.sv
module owm_master
  import owm_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int DIV_INIT   = 50,
  parameter int RST_LOW    = 480,
  parameter int RST_WAIT   = 70,
  parameter int RST_TAIL   = 410,
  parameter int W1_LOW     = 6,
  parameter int W0_LOW     = 60,
  parameter int SLOT_TICKS = 70,
  parameter int RD_SMP     = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [2:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  input  logic       line_i,
  output logic       line_pd_o
);
  logic [7:0]       cmd_q;
  logic [7:0]       ctrl_q;
  logic [DIV_W-1:0] div_q;
  logic             tick;
  logic             busy;
  logic             slot_pd;
  logic [7:0]       rx;
  logic             pres;
  logic             nopres;
  logic             rst_done;
  logic             cmd_wr;
  logic             data_wr;
  logic             start_rst;
  logic             start_byte;
  logic             force_on;

  assign cmd_wr     = wr_en_i && wr_addr_i == ADDR_CMD && !busy;
  assign data_wr    = wr_en_i && wr_addr_i == ADDR_DATA;
  assign start_rst  = cmd_wr && wr_data_i[CMD_RST_BIT];
  assign start_byte = data_wr && !busy && rst_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      ctrl_q <= '0;
      div_q  <= DIV_W'(DIV_INIT);
    end else if (wr_en_i) begin
      if (cmd_wr)                 cmd_q  <= wr_data_i;
      if (wr_addr_i == ADDR_CTRL) ctrl_q <= wr_data_i;
      if (wr_addr_i == ADDR_DIV)  div_q  <= wr_data_i[DIV_W-1:0];
    end
  end

  owm_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div_q),
    .tick_o (tick)
  );

  owm_slot_engine #(
    .RST_LOW    (RST_LOW),
    .RST_WAIT   (RST_WAIT),
    .RST_TAIL   (RST_TAIL),
    .W1_LOW     (W1_LOW),
    .W0_LOW     (W0_LOW),
    .SLOT_TICKS (SLOT_TICKS),
    .RD_SMP     (RD_SMP)
  ) u_engine (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .start_rst_i  (start_rst),
    .start_byte_i (start_byte),
    .tx_i         (wr_data_i),
    .line_i       (line_i),
    .busy_o       (busy),
    .pd_o         (slot_pd),
    .rx_o         (rx),
    .presence_o   (pres),
    .nopres_o     (nopres),
    .rst_done_o   (rst_done)
  );

  // Override is gated by the enable so a stray command bit cannot hold the bus
  assign force_on  = ctrl_q[CTRL_FEN_BIT] && cmd_q[CMD_FORCE_BIT];
  assign line_pd_o = slot_pd || force_on;

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      ADDR_CMD:  rd_data_o = cmd_q;
      ADDR_CTRL: rd_data_o = ctrl_q;
      ADDR_DIV:  rd_data_o = 8'(div_q);
      ADDR_DATA: rd_data_o = rx;
      ADDR_STAT: rd_data_o = {4'b0, rst_done, nopres, pres, busy};
      default:   rd_data_o = '0;
    endcase
  end

  // R4: a data write before any completed reset leaves the block idle
  p_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && !rst_done && !busy && !start_rst) |=> !busy);

  // R8: without the enable only the slot engine may pull the line
  p_force_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q[CTRL_FEN_BIT] && !slot_pd) |-> !line_pd_o);
endmodule

// File: tb/tb_owm_master.sv
module tb_owm_master;
  localparam int RL = 12, RW = 4, RT = 6, W1 = 2, W0 = 8, ST = 10, RS = 4;
  localparam int DINIT = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = 3'd4;
  logic [7:0] rd_data;
  logic       line_pd;
  logic       line;
  logic       slave_pull = 1'b0;
  int         smode = 0;
  logic [7:0] sbyte = '0;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign line = !(line_pd | slave_pull);

  owm_master #(.DIV_W(8), .DIV_INIT(DINIT), .RST_LOW(RL), .RST_WAIT(RW),
    .RST_TAIL(RT), .W1_LOW(W1), .W0_LOW(W0), .SLOT_TICKS(ST), .RD_SMP(RS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .line_i(line), .line_pd_o(line_pd));

  // behavioural reference
  int m_div, m_cnt, m_kind, m_t, m_bit;
  logic [7:0] m_cmd, m_ctrl, m_tx, m_rx;
  bit m_pres, m_nop, m_done;

  function automatic int m_low();
    if (m_kind == 1) return RL;
    return m_tx[0] ? W1 : W0;
  endfunction

  function automatic bit exp_pd();
    return (m_kind != 0 && m_t < m_low()) || (m_ctrl[2] && m_cmd[2]);
  endfunction

  function automatic logic [7:0] exp_stat();
    return {4'b0, m_done, m_nop, m_pres, m_kind != 0};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int lim, smp, tot;
    bit tk, ln, busy, srst, sbyt;
    if (!rst_n) begin
      m_div = DINIT; m_cnt = 0; m_kind = 0; m_t = 0; m_bit = 0;
      m_cmd = 0; m_ctrl = 0; m_tx = 0; m_rx = 0;
      m_pres = 0; m_nop = 0; m_done = 0;
    end else begin
      lim = (m_div == 0) ? 0 : m_div - 1;
      tk = (m_cnt >= lim);
      m_cnt = tk ? 0 : m_cnt + 1;
      ln = !(exp_pd() | slave_pull);
      busy = (m_kind != 0);
      srst = 0; sbyt = 0;
      if (wr_en) begin
        if (wr_addr == 3'd0 && !busy) begin m_cmd = wr_data; srst = wr_data[0]; end
        if (wr_addr == 3'd1) m_ctrl = wr_data;
        if (wr_addr == 3'd2) m_div = wr_data;
        if (wr_addr == 3'd3 && !busy && m_done) sbyt = 1;
      end
      smp = (m_kind == 1) ? RL + RW : RS;
      tot = (m_kind == 1) ? RL + RW + RT : ST;
      if (srst) begin
        m_kind = 1; m_t = 0; m_pres = 0; m_nop = 0;
      end else if (sbyt) begin
        m_kind = 2; m_t = 0; m_bit = 0; m_tx = wr_data;
      end else if (busy && tk) begin
        m_t = m_t + 1;
        if (m_t == smp) begin
          if (m_kind == 1) begin m_pres = !ln; m_nop = ln; end
          else m_rx = {ln, m_rx[7:1]};
        end
        if (m_t == tot) begin
          m_t = 0;
          if (m_kind == 1) begin m_kind = 0; m_done = 1; end
          else if (m_bit == 7) m_kind = 0;
          else begin m_bit = m_bit + 1; m_tx = m_tx >> 1; end
        end
      end
    end
  end

  // bench-side device on the bus
  always @(negedge clk)
    slave_pull <= (smode == 1 && m_kind == 1 && m_t >= RL) ||
                  (smode == 2 && m_kind == 2 && !sbyte[m_bit]);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison: R1 R2 R5 R7 R8 line and R3 R4 R7 status
  always @(negedge clk) begin
    #2;
    if (rst_n && !finished) begin
      chk(line_pd === exp_pd(), "R2/R5/R8 line", line_pd, exp_pd());
      if (rd_addr == 3'd4)
        chk(rd_data === exp_stat(), "R3/R4/R7 status", rd_data, exp_stat());
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
    rd_addr = 3'd4;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (rd_data[0] == 1'b0) break;
    end
  endtask

  task automatic reset_measure(input int d, output int low);
    low = 0;
    wr(3'd0, 8'h01);
    for (int i = 0; i < 20000; i++) begin
      if (line_pd) low++;
      if (rd_data[0] == 1'b0) break;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [7:0] v;
    int low;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    rd(3'd4, v); chk(v == 8'h00, "R9 status", v, 0);
    rd(3'd2, v); chk(v == DINIT, "R9 divisor", v, DINIT);
    rd(3'd3, v); chk(v == 8'h00, "R9 rx", v, 0);
    chk(line_pd == 1'b0, "R9 line", line_pd, 0);

    wr(3'd2, 8'd3);
    // R4: byte before reset is ignored
    wr(3'd3, 8'h00);
    repeat (3) @(negedge clk);
    chk(rd_data[0] == 1'b0, "R4 busy", rd_data[0], 0);
    chk(line_pd == 1'b0, "R4 line", line_pd, 0);

    // R2 R3 reset without device
    smode = 0;
    reset_measure(3, low);
    chk(low >= (RL-1)*3+1 && low <= RL*3, "R2 low span", low, RL*3);
    rd(3'd4, v); chk(v == 8'h0C, "R3 no presence", v, 8'h0C);

    // R3 with device
    smode = 1;
    wr(3'd0, 8'h01); wait_idle();
    rd(3'd4, v); chk(v == 8'h0A, "R3 presence", v, 8'h0A);

    // R5 R6 write byte, device silent
    smode = 2; sbyte = 8'hFF;
    wr(3'd3, 8'hA5); wait_idle();
    rd(3'd3, v); chk(v == 8'hA5, "R5 echo", v, 8'hA5);

    // R6 read byte
    sbyte = 8'h3C;
    wr(3'd3, 8'hFF); wait_idle();
    rd(3'd3, v); chk(v == 8'h3C, "R6 read", v, 8'h3C);

    // R7 writes while busy are ignored
    sbyte = 8'h5A;
    wr(3'd3, 8'hFF);
    repeat (40) @(negedge clk);
    wr(3'd0, 8'h01);
    wr(3'd3, 8'h00);
    wait_idle();
    rd(3'd3, v); chk(v == 8'h5A, "R7 rx kept", v, 8'h5A);
    rd(3'd4, v); chk(v == 8'h0A, "R7 status kept", v, 8'h0A);
    rd(3'd0, v); chk(v == 8'h01, "R7 cmd kept", v, 8'h01);

    // R8 force override
    smode = 0;
    wr(3'd0, 8'h04);
    repeat (2) @(negedge clk);
    chk(line_pd == 1'b0, "R8 disabled", line_pd, 0);
    wr(3'd1, 8'h04);
    @(negedge clk);
    chk(line_pd == 1'b1, "R8 enabled", line_pd, 1);
    wr(3'd1, 8'h00);
    @(negedge clk);
    chk(line_pd == 1'b0, "R8 released", line_pd, 0);
    wr(3'd0, 8'h00);

    // R1 divisor 1 and 0
    wr(3'd2, 8'd1);
    reset_measure(1, low);
    chk(low == RL, "R1 div1", low, RL);
    wr(3'd2, 8'd0);
    reset_measure(1, low);
    chk(low == RL, "R1 div0", low, RL);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule